// File: doc/BRIEF.md
# Structured interleaver address generator

This block produces the address stream of a block interleaver for a frame of K = m·z elements. The permutation is the composition of four steps. First, a z-row by m-column transposition. Second, a right circular shift of each group by its own amount. Third, a reordering of the groups. Fourth, the dual m-row by z-column transposition. The block does not store a full-length permutation table. For input index i it evaluates the closed form P(i mod m) + m·((δ(i mod m) + ⌊i/m⌋) mod z) from two short tables: a group map P and a shift table δ, each holding m entries.

Software-side logic loads the two tables through a small write port while the block is idle, sets the frame shape on `cfg_m` and `cfg_z`, and pulses `start`. The block then presents one address per accepted valid/ready handshake, for i = 0 up to K−1. It flags the final one and raises `done` once that address has been taken. A deinterleaver is obtained by loading inverse tables. The data memory that consumes the addresses lies outside the block.

Top module: `perm_addr_gen`

## Requirements
- R1: While reset is low, and on the first cycle after reset, `out_valid` and `done` are 0.
- R2: A `start` pulse while idle raises `out_valid` on the next cycle, clears `done`, and begins at index 0. A `start` while a stream is in progress has no effect on the stream.
- R3: The address presented for index i equals P(i mod m) + m·((δ(i mod m) + ⌊i/m⌋) mod z). This is identical to composing the two transpositions, the per-group shift and the group reordering.
- R4: The index advances only on a cycle where `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_addr` holds its value and `out_valid` stays 1.
- R5: `out_last` is 1 only while index K−1 is presented. On the cycle after that address is accepted, `out_valid` is 0 and `done` is 1. `done` stays 1 until the next start.
- R6: A table write takes effect when `tbl_we` is 1 and no stream is in progress. `tbl_sel` = 0 writes entry `tbl_addr` of the group map P; `tbl_sel` = 1 writes entry `tbl_addr` of the shift table δ. Writes attempted during a stream are ignored.
- R7: `cfg_m` and `cfg_z` are captured at start. Changing them during a stream does not alter it.
- R8: When P is a permutation of 0..m−1 and every δ(k) < z, the K addresses of one stream are all below K and each appears exactly once.
- R9: The degenerate shapes m = 1 and z = 1, including K = 1, stream correctly. With K = 1 the single address carries `out_last`.
- R10: With m = 3, z = 4, P = [1, 0, 2] and δ = [1, 3, 0], the stream begins 4, 9, 2, 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_m | input | $clog2(MAX_M+1) | Number of groups m (1..MAX_M), captured at start |
| cfg_z | input | $clog2(MAX_Z+1) | Group size z (1..MAX_Z), captured at start |
| tbl_we | input | 1 | Table write enable, honoured only while idle |
| tbl_sel | input | 1 | 0 selects the group map, 1 selects the shift table |
| tbl_addr | input | $clog2(MAX_M) | Table entry index k |
| tbl_data | input | max of table widths | Entry value P(k) or δ(k) |
| start | input | 1 | Begin a stream when idle |
| out_ready | input | 1 | Consumer accepts the presented address |
| out_valid | output | 1 | An address is presented |
| out_addr | output | $clog2(MAX_M·MAX_Z) | Interleaved address for the current index |
| out_last | output | 1 | The presented address is the final one, for index K−1 |
| done | output | 1 | The last stream has completed |

## Verification
`out_valid` and index 0 appear one clock edge after `start` is seen. `out_addr` is formed from registered counters, so it already reflects the current index in the cycle where it is presented, and it moves on at the edge that completes a handshake. `done` rises, and `out_valid` falls, one edge after the handshake of index K−1. The bench changes inputs on the falling edge and reads outputs at that same falling edge. Each read therefore sees the state left by the preceding rising edge, together with the `out_ready` value that will decide the next one. A handshake is scored exactly when `out_valid` and the driven `out_ready` are both 1 at that point.

// File: rtl/perm_addr_gen.sv
module perm_addr_gen #(
  parameter int MAX_M = 16,
  parameter int MAX_Z = 64,
  localparam int CW  = $clog2(MAX_M),
  localparam int RW  = $clog2(MAX_Z),
  localparam int MCW = $clog2(MAX_M + 1),
  localparam int ZCW = $clog2(MAX_Z + 1),
  localparam int AW  = $clog2(MAX_M * MAX_Z),
  localparam int TW  = (CW > RW) ? CW : RW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MCW-1:0] cfg_m,
  input  logic [ZCW-1:0] cfg_z,
  input  logic           tbl_we,
  input  logic           tbl_sel,
  input  logic [CW-1:0]  tbl_addr,
  input  logic [TW-1:0]  tbl_data,
  input  logic           start,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr,
  output logic           out_last,
  output logic           done
);

  logic [CW-1:0]  grp_tbl [MAX_M];
  logic [RW-1:0]  sh_tbl  [MAX_M];
  logic           active;
  logic           done_q;
  logic [MCW-1:0] m_q;
  logic [ZCW-1:0] z_q;
  logic [CW-1:0]  col;
  logic [RW-1:0]  row;

  wire col_end = (MCW'(col) == m_q - MCW'(1));
  wire row_end = (ZCW'(row) == z_q - ZCW'(1));
  wire fire    = active && out_ready;

  wire [RW:0] ssum = {1'b0, sh_tbl[col]} + {1'b0, row};
  wire [RW:0] zx   = (RW+1)'(z_q);
  wire [RW:0] sred = (ssum >= zx) ? ssum - zx : ssum;

  assign out_valid = active;
  assign out_addr  = AW'(m_q) * AW'(sred[RW-1:0]) + AW'(grp_tbl[col]);
  assign out_last  = active && col_end && row_end;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_M; k++) begin
        grp_tbl[k] <= '0;
        sh_tbl[k]  <= '0;
      end
    end else if (tbl_we && !active) begin
      if (tbl_sel) sh_tbl[tbl_addr]  <= tbl_data[RW-1:0];
      else         grp_tbl[tbl_addr] <= tbl_data[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done_q <= 1'b0;
      m_q    <= MCW'(1);
      z_q    <= ZCW'(1);
      col    <= '0;
      row    <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      done_q <= 1'b0;
      m_q    <= cfg_m;
      z_q    <= cfg_z;
      col    <= '0;
      row    <= '0;
    end else if (fire) begin
      if (col_end) begin
        col <= '0;
        if (row_end) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          row <= row + RW'(1);
        end
      end else begin
        col <= col + CW'(1);
      end
    end
  end

endmodule

// File: rtl/perm_addr_gen_chk.sv
module perm_addr_gen_chk #(
  parameter int MAX_M = 16,
  parameter int MAX_Z = 64,
  localparam int MCW = $clog2(MAX_M + 1),
  localparam int ZCW = $clog2(MAX_Z + 1),
  localparam int AW  = $clog2(MAX_M * MAX_Z)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           out_ready,
  input logic           out_valid,
  input logic [AW-1:0]  out_addr,
  input logic           out_last,
  input logic           done,
  input logic [MCW-1:0] m_q,
  input logic [ZCW-1:0] z_q
);

  logic [AW:0] k_len;
  assign k_len = (AW+1)'(m_q) * (AW+1)'(z_q);

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((AW+1)'(out_addr) < k_len)); // R8

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done && !out_valid); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R5

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    start && !out_valid |=> out_valid && !done); // R2

endmodule

bind perm_addr_gen perm_addr_gen_chk #(.MAX_M(MAX_M), .MAX_Z(MAX_Z)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
  .out_valid(out_valid), .out_addr(out_addr), .out_last(out_last),
  .done(done), .m_q(m_q), .z_q(z_q)
);

// File: tb/test_perm_addr_gen.sv
`timescale 1ns/1ps
module test_perm_addr_gen;
  localparam int MAX_M = 16;
  localparam int MAX_Z = 64;
  localparam int CW  = $clog2(MAX_M);
  localparam int RW  = $clog2(MAX_Z);
  localparam int MCW = $clog2(MAX_M + 1);
  localparam int ZCW = $clog2(MAX_Z + 1);
  localparam int AW  = $clog2(MAX_M * MAX_Z);
  localparam int TW  = (CW > RW) ? CW : RW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [MCW-1:0] cfg_m = '0;
  logic [ZCW-1:0] cfg_z = '0;
  logic           tbl_we = 1'b0, tbl_sel = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [CW-1:0]  tbl_addr = '0;
  logic [TW-1:0]  tbl_data = '0;
  logic           out_valid, out_last, done;
  logic [AW-1:0]  out_addr;

  perm_addr_gen #(.MAX_M(MAX_M), .MAX_Z(MAX_Z)) i_perm_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_z(cfg_z),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .start(start), .out_ready(out_ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_last(out_last), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int tb_p [MAX_M];
  int tb_d [MAX_M];
  int got  [MAX_M*MAX_Z];
  bit seen [MAX_M*MAX_Z];

  task automatic chk_eq(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int exp_addr(int i, int m, int z);
    int a1 = (i % m) * z + i / m;
    int g  = a1 / z;
    int a2 = g * z + ((a1 % z) + tb_d[g]) % z;
    int a3 = tb_p[a2 / z] * z + a2 % z;
    return (a3 % z) * m + a3 / z;
  endfunction

  task automatic wr(bit sel, int a, int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = CW'(a); tbl_data = TW'(d);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load(int m);
    for (int k = 0; k < m; k++) begin
      wr(1'b0, k, tb_p[k]);
      wr(1'b1, k, tb_d[k]);
    end
  endtask

  task automatic rand_tables(int m, int z);
    for (int k = 0; k < m; k++) begin
      tb_p[k] = k;
      tb_d[k] = $urandom_range(z - 1);
    end
    for (int k = m - 1; k > 0; k--) begin
      int j = $urandom_range(k);
      int t = tb_p[k];
      tb_p[k] = tb_p[j];
      tb_p[j] = t;
    end
  endtask

  task automatic run(int m, int z, int pct, bit disturb);
    int kl = m * z;
    int idx = 0;
    int cnt = 0;
    for (int a = 0; a < kl; a++) seen[a] = 1'b0;
    cfg_m = MCW'(m); cfg_z = ZCW'(z);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_eq("R2 valid after start", int'(out_valid), 1);
    chk_eq("R2 done cleared", int'(done), 0);
    if (disturb) begin
      cfg_m = MCW'((m % MAX_M) + 1);
      cfg_z = ZCW'((z % MAX_Z) + 1);
    end
    while (idx < kl) begin
      out_ready = ($urandom_range(99) < pct);
      if (disturb && idx == kl / 2) begin
        start = 1'b1; tbl_we = 1'b1; tbl_sel = idx[0];
        tbl_addr = '0; tbl_data = TW'(m - 1 + z - 1);
      end else begin
        start = 1'b0; tbl_we = 1'b0;
      end
      if (!out_valid) chk_eq("R4 valid held during stream", 0, 1);
      if (out_valid && out_ready) begin
        got[idx] = int'(out_addr);
        chk_eq("R3 address", int'(out_addr), exp_addr(idx, m, z));
        chk_eq("R5 last flag", int'(out_last), (idx == kl - 1) ? 1 : 0);
        if (int'(out_addr) < kl) begin
          if (seen[out_addr]) chk_eq("R8 duplicate address", int'(out_addr), -1);
          seen[out_addr] = 1'b1;
        end
        idx++;
      end
      @(negedge clk);
    end
    start = 1'b0; tbl_we = 1'b0; out_ready = 1'b0;
    chk_eq("R5 done after last", int'(done), 1);
    chk_eq("R5 valid low after last", int'(out_valid), 0);
    for (int a = 0; a < kl; a++) cnt += seen[a] ? 1 : 0;
    chk_eq("R8 permutation coverage", cnt, kl);
    @(negedge clk);
    chk_eq("R5 done held", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_eq("R1 valid in reset", int'(out_valid), 0);
    chk_eq("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 valid after reset", int'(out_valid), 0);
    chk_eq("R1 done after reset", int'(done), 0);

    tb_p[0] = 1; tb_p[1] = 0; tb_p[2] = 2;
    tb_d[0] = 1; tb_d[1] = 3; tb_d[2] = 0;
    load(3);
    run(3, 4, 100, 1'b0);
    chk_eq("R10 first", got[0], 4);
    chk_eq("R10 second", got[1], 9);
    chk_eq("R10 third", got[2], 2);
    chk_eq("R10 fourth", got[3], 7);

    // R9 degenerate shapes
    tb_p[0] = 0; tb_d[0] = 0;
    load(1);
    run(1, 1, 100, 1'b0);
    chk_eq("R9 single address", got[0], 0);
    tb_d[0] = 3;
    load(1);
    run(1, 5, 60, 1'b0);
    rand_tables(7, 1);
    load(7);
    run(7, 1, 60, 1'b0);

    // R6 R7 R2: disturbances during a stream, then rerun without reloading
    rand_tables(5, 9);
    load(5);
    run(5, 9, 70, 1'b1);
    run(5, 9, 70, 1'b0);

    rand_tables(MAX_M, MAX_Z);
    load(MAX_M);
    run(MAX_M, MAX_Z, 80, 1'b0);

    for (int n = 0; n < 8; n++) begin
      int m = $urandom_range(MAX_M - 1) + 1;
      int z = $urandom_range(MAX_Z - 1) + 1;
      rand_tables(m, z);
      load(m);
      run(m, z, 30 + 10 * n, n[0]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule